// File: doc/BRIEF.md
# I2C Auto-Mode Transaction Sequencer

This block is the master side of an I2C controller that carries out a whole transfer from a single command. The caller supplies a 7-bit or 10-bit target address, a nonzero byte count, a direction and a flag that says whether the bus is released at the end, and pulses a run input. The engine then issues START, sends the address bytes, moves data between the bus and its own transmit and receive FIFOs, and finishes either with STOP or by keeping the bus for a repeated START. No per-byte handshake is needed.

Bit-level SCL/SDA phase timing belongs to a separate timing generator. The engine talks to it through a request/done handshake. It asks for START, STOP or a single data bit, and receives back the sampled SDA level and an arbitration-lost flag. A separate input reports that another device is holding SCL low, which feeds a programmable timeout. The outcome is reported as exactly one flag in a status word, together with a completion interrupt flag that is cleared by writing a 1 to it.

Top module: `i2c_auto_seq`

## Requirements
- R1: A run pulse with a nonzero length makes `xfer_busy` high in the next cycle, clears `xfer_status`, and issues START first. A run with length zero is refused: busy stays low, no bit command is issued and the status is unchanged. Bit command encoding on `bit_cmd`: 0 = START, 1 = STOP, 2 = data bit.
- R2: Address bytes go out MSB first. In 7-bit mode the byte is {addr[6:0], rw}. In 10-bit mode the bytes are {5'b11110, addr[9:8], 0} and then addr[7:0]. A 10-bit read then issues a repeated START and {5'b11110, addr[9:8], 1}.
- R3: A write pops bytes from the TX FIFO in order and sends each MSB first. It drives 1 in the acknowledge slot and ends with success after the programmed count.
- R4: A read drives 1 for every data bit and pushes each byte into the RX FIFO. In the acknowledge slot it drives 0 for every byte except the last, for which it drives 1.
- R5: STOP is issued at the end only if the stop flag was set and the transfer was neither aborted nor timed out. Without it, the next transfer begins with a START that is a repeated start.
- R6: A NACK on any address byte sets no-device (status bit 3). A NACK on a written data byte sets not-acknowledged (bit 2). Both end the transfer, with STOP if requested.
- R7: Loss of arbitration sets abort (bit 1) and ends the transfer at once, without STOP.
- R8: While `to_en` is high, `scl_held_low` asserted for more than `to_limit` consecutive busy cycles sets timeout (bit 4) and ends the transfer without STOP. With `to_en` low, no timeout occurs.
- R9: A write issues no data-bit command while the TX FIFO is empty. A read issues no bit command for a new byte while the RX FIFO is full. Both resume once software services the FIFO.
- R10: `xfer_status` bit 0 is success. At the end exactly one bit is set, `irq_done` is set in the same cycle that busy falls, and `irq_clr` clears `irq_done`.
- R11: `fifo_stat` layout: TX level [6:0], TX full 7, TX empty 8, RX level [22:16], RX full 23, RX empty 24, other bits 0. A push into a full FIFO or a pop from an empty one has no effect.
- R12: When STOP is requested, busy stays high until the STOP command has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_run | input | 1 | Start pulse for a transfer |
| cmd_len | input | LEN_W | Byte count |
| cmd_rd | input | 1 | 1 = read, 0 = write |
| cmd_stop | input | 1 | Issue STOP at the end |
| tgt_ten | input | 1 | 10-bit addressing |
| tgt_addr | input | 10 | Target address |
| to_en | input | 1 | Timeout enable |
| to_limit | input | TO_W | Timeout cycle count |
| tx_push | input | 1 | Write TX FIFO |
| tx_data | input | 8 | TX byte |
| rx_pop | input | 1 | Read RX FIFO |
| rx_data | output | 8 | Head of RX FIFO |
| fifo_stat | output | 25 | FIFO levels and flags |
| xfer_status | output | 5 | Outcome flags |
| xfer_busy | output | 1 | Transfer in progress |
| irq_done | output | 1 | Completion interrupt flag |
| irq_clr | input | 1 | Write-1 clear of irq_done |
| bit_req | output | 1 | Bit command request |
| bit_cmd | output | 2 | Bit command code |
| bit_wbit | output | 1 | SDA value to drive for a data bit |
| bit_done | input | 1 | Bit command complete |
| bit_rx | input | 1 | Sampled SDA |
| bit_arb_lost | input | 1 | Arbitration lost on this command |
| scl_held_low | input | 1 | SCL held low by another device |

## Verification
If the engine's state or byte counter goes wrong, the first sign is on the bit-command port within one byte time. An address or data byte arrives at the modelled target with wrong content, or an acknowledge slot carries the wrong level; for example, the last read byte is acknowledged instead of NACKed. A wrong outcome shows as a different status bit or a missing or extra STOP when busy falls. A broken stall condition shows as bit commands continuing while a FIFO is empty or full.

// File: rtl/i2c_auto_pkg.sv
package i2c_auto_pkg;

    typedef enum logic [1:0] {
        BC_START = 2'd0,
        BC_STOP  = 2'd1,
        BC_BIT   = 2'd2
    } bitcmd_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_START, ST_ADDR, ST_WAIT_TX, ST_WR,
        ST_WAIT_RX, ST_RD, ST_STOP, ST_END
    } seq_state_e;

    localparam int STAT_W   = 5;
    localparam int F_OK     = 0;
    localparam int F_ABORT  = 1;
    localparam int F_NACK   = 2;
    localparam int F_NODEV  = 3;
    localparam int F_TOUT   = 4;
    localparam int FSTAT_W  = 25;
    localparam int LVL_FLD  = 7;

    typedef struct packed {
        logic [9:0] addr;
        logic       ten;
        logic       rd;
        logic       stop;
    } xfer_cfg_t;

    function automatic logic [STAT_W-1:0] flag(input int pos);
        flag = STAT_W'(1) << pos;
    endfunction

    // step 0: first byte, 1: low address byte, 2: read header after Sr
    function automatic logic [7:0] addr_byte(input logic [9:0] a, input logic ten,
                                             input logic rd, input logic [1:0] step);
        if (!ten)           addr_byte = {a[6:0], rd};
        else if (step == 0) addr_byte = {5'b11110, a[9:8], 1'b0};
        else if (step == 1) addr_byte = a[7:0];
        else                addr_byte = {5'b11110, a[9:8], 1'b1};
    endfunction

endpackage

// File: rtl/i2c_seq_fifo.sv
module i2c_seq_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 8,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     dout,
    output logic             full,
    output logic             empty,
    output logic [LVL_W-1:0] level
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign full    = (level == LVL_W'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        nxt = (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (do_push) begin
                mem[wp] <= din;
                wp      <= nxt(wp);
            end
            if (do_pop) rp <= nxt(rp);
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    a_r11_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> (level == LVL_W'(DEPTH)));
    a_r11_no_underflow: assert property (@(posedge clk) disable iff (rst)
        (empty && pop && !push) |=> (level == '0));
endmodule

// File: rtl/i2c_seq_tmo.sv
module i2c_seq_tmo #(
    parameter int TO_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            active,
    input  logic            en,
    input  logic            scl_low,
    input  logic [TO_W-1:0] limit,
    output logic            fire
);
    logic [TO_W-1:0] cnt;
    logic            hold;

    assign hold = active && en && scl_low;
    assign fire = hold && (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst || !hold) cnt <= '0;
        else if (cnt != limit) cnt <= cnt + 1'b1;
    end

    a_r8_fire_after_hold: assert property (@(posedge clk) disable iff (rst)
        (fire && limit != '0) |-> $past(scl_low && en));
endmodule

// File: rtl/i2c_seq_ctrl.sv
module i2c_seq_ctrl
    import i2c_auto_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [LEN_W-1:0]  len,
    input  xfer_cfg_t         cfg,
    input  logic              tx_empty,
    input  logic [7:0]        tx_data,
    output logic              tx_pop,
    input  logic              rx_full,
    output logic              rx_push,
    output logic [7:0]        rx_wdata,
    input  logic              tmo_fire,
    output logic              busy,
    output logic              bit_req,
    output logic [1:0]        bit_cmd,
    output logic              bit_wbit,
    input  logic              bit_done,
    input  logic              bit_rx,
    input  logic              bit_lost,
    output logic [STAT_W-1:0] status,
    output logic              irq,
    input  logic              irq_clr
);
    seq_state_e        state;
    xfer_cfg_t         cq;
    logic [LEN_W-1:0]  cnt;
    logic [1:0]        step;
    logic [3:0]        bitn;
    logic [7:0]        sh;
    logic [STAT_W-1:0] res;
    seq_state_e        end_next;
    logic              slot;

    assign busy     = (state != ST_IDLE);
    assign end_next = cq.stop ? ST_STOP : ST_END;
    assign slot     = (bitn == 4'd8);
    assign rx_wdata = sh;
    assign tx_pop   = (state == ST_WAIT_TX) && !tx_empty && !tmo_fire;
    assign rx_push  = (state == ST_RD) && bit_done && !bit_lost && slot && !tmo_fire;

    always_comb begin
        bit_req  = 1'b0;
        bit_cmd  = BC_BIT;
        bit_wbit = 1'b1;
        case (state)
            ST_START: begin bit_req = 1'b1; bit_cmd = BC_START; end
            ST_STOP:  begin bit_req = 1'b1; bit_cmd = BC_STOP; end
            ST_ADDR, ST_WR: begin
                bit_req  = 1'b1;
                bit_wbit = slot ? 1'b1 : sh[7];
            end
            ST_RD: begin
                bit_req  = 1'b1;
                bit_wbit = slot ? (cnt == LEN_W'(1)) : 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cq     <= '0;
            cnt    <= '0;
            step   <= '0;
            bitn   <= '0;
            sh     <= '0;
            res    <= '0;
            status <= '0;
            irq    <= 1'b0;
        end else begin
            if (irq_clr) irq <= 1'b0;
            case (state)
                ST_IDLE: if (run && len != '0) begin
                    cq     <= cfg;
                    cnt    <= len;
                    step   <= '0;
                    status <= '0;
                    state  <= ST_START;
                end
                ST_END: begin
                    status <= res;
                    irq    <= 1'b1;
                    state  <= ST_IDLE;
                end
                default: begin
                    if (tmo_fire) begin
                        res   <= flag(F_TOUT);
                        state <= ST_END;
                    end else if (bit_done && bit_lost) begin
                        res   <= flag(F_ABORT);
                        state <= ST_END;
                    end else begin
                        case (state)
                            ST_START: if (bit_done) begin
                                sh    <= addr_byte(cq.addr, cq.ten, cq.rd, step);
                                bitn  <= '0;
                                state <= ST_ADDR;
                            end
                            ST_ADDR: if (bit_done) begin
                                if (!slot) begin
                                    sh   <= {sh[6:0], 1'b0};
                                    bitn <= bitn + 1'b1;
                                end else if (bit_rx) begin
                                    res   <= flag(F_NODEV);
                                    state <= end_next;
                                end else if (cq.ten && step == 2'd0) begin
                                    step <= 2'd1;
                                    sh   <= addr_byte(cq.addr, 1'b1, cq.rd, 2'd1);
                                    bitn <= '0;
                                end else if (cq.ten && step == 2'd1 && cq.rd) begin
                                    step  <= 2'd2;
                                    state <= ST_START;
                                end else begin
                                    state <= cq.rd ? ST_WAIT_RX : ST_WAIT_TX;
                                end
                            end
                            ST_WAIT_TX: if (!tx_empty) begin
                                sh    <= tx_data;
                                bitn  <= '0;
                                state <= ST_WR;
                            end
                            ST_WR: if (bit_done) begin
                                if (!slot) begin
                                    sh   <= {sh[6:0], 1'b0};
                                    bitn <= bitn + 1'b1;
                                end else if (bit_rx) begin
                                    res   <= flag(F_NACK);
                                    state <= end_next;
                                end else if (cnt == LEN_W'(1)) begin
                                    res   <= flag(F_OK);
                                    state <= end_next;
                                end else begin
                                    cnt   <= cnt - 1'b1;
                                    state <= ST_WAIT_TX;
                                end
                            end
                            ST_WAIT_RX: if (!rx_full) begin
                                bitn  <= '0;
                                state <= ST_RD;
                            end
                            ST_RD: if (bit_done) begin
                                if (!slot) begin
                                    sh   <= {sh[6:0], bit_rx};
                                    bitn <= bitn + 1'b1;
                                end else if (cnt == LEN_W'(1)) begin
                                    res   <= flag(F_OK);
                                    state <= end_next;
                                end else begin
                                    cnt   <= cnt - 1'b1;
                                    state <= ST_WAIT_RX;
                                end
                            end
                            ST_STOP: if (bit_done) state <= ST_END;
                            default: state <= ST_IDLE;
                        endcase
                    end
                end
            endcase
        end
    end

    a_r1_zero_len_refused: assert property (@(posedge clk) disable iff (rst)
        (!busy && run && len == '0) |=> !busy);
    a_r10_irq_at_end: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $fell(busy));
    a_r10_status_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(status));
    a_r9_rx_room: assert property (@(posedge clk) disable iff (rst)
        rx_push |-> !rx_full);
endmodule

// File: rtl/i2c_auto_seq.sv
module i2c_auto_seq
    import i2c_auto_pkg::*;
#(
    parameter int LEN_W    = 8,
    parameter int TO_W     = 16,
    parameter int TX_DEPTH = 8,
    parameter int RX_DEPTH = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_run,
    input  logic [LEN_W-1:0]   cmd_len,
    input  logic               cmd_rd,
    input  logic               cmd_stop,
    input  logic               tgt_ten,
    input  logic [9:0]         tgt_addr,
    input  logic               to_en,
    input  logic [TO_W-1:0]    to_limit,
    input  logic               tx_push,
    input  logic [7:0]         tx_data,
    input  logic               rx_pop,
    output logic [7:0]         rx_data,
    output logic [FSTAT_W-1:0] fifo_stat,
    output logic [STAT_W-1:0]  xfer_status,
    output logic               xfer_busy,
    output logic               irq_done,
    input  logic               irq_clr,
    output logic               bit_req,
    output logic [1:0]         bit_cmd,
    output logic               bit_wbit,
    input  logic               bit_done,
    input  logic               bit_rx,
    input  logic               bit_arb_lost,
    input  logic               scl_held_low
);
    localparam int TLW = $clog2(TX_DEPTH + 1);
    localparam int RLW = $clog2(RX_DEPTH + 1);

    logic [7:0]     txq_dout, rxq_din;
    logic           txq_pop, txq_full, txq_empty;
    logic           rxq_push, rxq_full, rxq_empty;
    logic [TLW-1:0] txq_lvl;
    logic [RLW-1:0] rxq_lvl;
    logic           tmo_fire;
    xfer_cfg_t      cfg;

    assign cfg = '{addr: tgt_addr, ten: tgt_ten, rd: cmd_rd, stop: cmd_stop};

    assign fifo_stat = {rxq_empty, rxq_full, LVL_FLD'(rxq_lvl), 7'b0,
                        txq_empty, txq_full, LVL_FLD'(txq_lvl)};

    i2c_seq_fifo #(.DEPTH(TX_DEPTH), .W(8)) u_txq (
        .clk(clk), .rst(rst), .push(tx_push), .din(tx_data), .pop(txq_pop),
        .dout(txq_dout), .full(txq_full), .empty(txq_empty), .level(txq_lvl));

    i2c_seq_fifo #(.DEPTH(RX_DEPTH), .W(8)) u_rxq (
        .clk(clk), .rst(rst), .push(rxq_push), .din(rxq_din), .pop(rx_pop),
        .dout(rx_data), .full(rxq_full), .empty(rxq_empty), .level(rxq_lvl));

    i2c_seq_tmo #(.TO_W(TO_W)) u_tmo (
        .clk(clk), .rst(rst), .active(xfer_busy), .en(to_en),
        .scl_low(scl_held_low), .limit(to_limit), .fire(tmo_fire));

    i2c_seq_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk(clk), .rst(rst), .run(cmd_run), .len(cmd_len), .cfg(cfg),
        .tx_empty(txq_empty), .tx_data(txq_dout), .tx_pop(txq_pop),
        .rx_full(rxq_full), .rx_push(rxq_push), .rx_wdata(rxq_din),
        .tmo_fire(tmo_fire), .busy(xfer_busy),
        .bit_req(bit_req), .bit_cmd(bit_cmd), .bit_wbit(bit_wbit),
        .bit_done(bit_done), .bit_rx(bit_rx), .bit_lost(bit_arb_lost),
        .status(xfer_status), .irq(irq_done), .irq_clr(irq_clr));
endmodule

// File: tb/i2c_auto_seq_tb_top.sv
module i2c_auto_seq_tb_top;
    localparam int DEPTH = 8;
    localparam int LAT   = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_run = 0, cmd_rd = 0, cmd_stop = 0, tgt_ten = 0;
    logic [7:0]  cmd_len = 0;
    logic [9:0]  tgt_addr = 0;
    logic        to_en = 0;
    logic [15:0] to_limit = 0;
    logic        tx_push = 0, rx_pop = 0, irq_clr = 0;
    logic [7:0]  tx_data = 0;
    logic [7:0]  rx_data;
    logic [24:0] fifo_stat;
    logic [4:0]  xfer_status;
    logic        xfer_busy, irq_done, bit_req, bit_wbit;
    logic [1:0]  bit_cmd;
    logic        bit_done = 0, bit_rx = 1, bit_arb_lost = 0, scl_held_low = 0;

    always #4 clk = ~clk;

    i2c_auto_seq dut_i (
        .clk(clk), .rst(rst), .cmd_run(cmd_run), .cmd_len(cmd_len), .cmd_rd(cmd_rd),
        .cmd_stop(cmd_stop), .tgt_ten(tgt_ten), .tgt_addr(tgt_addr), .to_en(to_en),
        .to_limit(to_limit), .tx_push(tx_push), .tx_data(tx_data), .rx_pop(rx_pop),
        .rx_data(rx_data), .fifo_stat(fifo_stat), .xfer_status(xfer_status),
        .xfer_busy(xfer_busy), .irq_done(irq_done), .irq_clr(irq_clr),
        .bit_req(bit_req), .bit_cmd(bit_cmd), .bit_wbit(bit_wbit), .bit_done(bit_done),
        .bit_rx(bit_rx), .bit_arb_lost(bit_arb_lost), .scl_held_low(scl_held_low));

    int vectors = 0, fails = 0, cyc = 0;

    // behavioural timing generator + target model
    int         lat = 0, bitpos = 0, bits_seen = 0, start_cnt = 0, stop_cnt = 0;
    int         present = 1, nack_at = -1, arb_at = -1, rd_idx = 0;
    bit         txmode = 0, first = 0, busy_at_stop = 0;
    logic [7:0] shreg = 0;
    logic [7:0] rcv[$];
    logic [7:0] rd_bytes[$];
    int         mack[$];

    task automatic respond();
        bit_arb_lost = 0;
        bit_rx = 1;
        case (bit_cmd)
            2'd0: begin start_cnt++; bitpos = 0; first = 1; txmode = 0; end
            2'd1: begin stop_cnt++; busy_at_stop = xfer_busy; end
            default: begin
                bits_seen++;
                if (bitpos < 8) begin
                    if (txmode) bit_rx = bit_wbit & rd_bytes[rd_idx][7-bitpos];
                    else begin
                        bit_rx = bit_wbit;
                        shreg = {shreg[6:0], bit_wbit};
                    end
                    if (bits_seen == arb_at && bit_wbit) begin
                        bit_arb_lost = 1;
                        bit_rx = 0;
                    end
                    bitpos++;
                end else begin
                    if (txmode) begin
                        mack.push_back(int'(bit_wbit));
                        bit_rx = bit_wbit;
                        rd_idx++;
                    end else begin
                        rcv.push_back(shreg);
                        bit_rx = (present == 0) || (rcv.size() - 1 == nack_at);
                        if (first && shreg[0] && !bit_rx) txmode = 1;
                        first = 0;
                    end
                    bitpos = 0;
                end
            end
        endcase
        bit_done = 1;
    endtask

    always @(negedge clk) begin
        if (bit_done) begin
            bit_done = 0;
            bit_arb_lost = 0;
            lat = 0;
        end else if (bit_req && !scl_held_low) begin
            lat++;
            if (lat == LAT) respond();
        end else if (!bit_req) lat = 0;
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
        end
    end

    task automatic chk(input string rq, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic cyc_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_tx(input logic [7:0] d);
        @(negedge clk);
        tx_push = 1; tx_data = d;
        @(negedge clk);
        tx_push = 0;
    endtask

    task automatic pop_chk(input string rq, input logic [7:0] exp);
        @(negedge clk);
        chk(rq, int'(rx_data), int'(exp));
        rx_pop = 1;
        @(negedge clk);
        rx_pop = 0;
    endtask

    task automatic go(input int len, input bit rd, input bit stp, input bit ten,
                      input logic [9:0] a);
        @(negedge clk);
        cmd_len = 8'(len); cmd_rd = rd; cmd_stop = stp; tgt_ten = ten; tgt_addr = a;
        cmd_run = 1;
        @(negedge clk);
        cmd_run = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20000 && xfer_busy; i++) @(negedge clk);
        cyc_n(3);
    endtask

    task automatic chk_rcv(input string rq, input logic [7:0] exp[$]);
        chk({rq, " byte count"}, rcv.size(), exp.size());
        for (int i = 0; i < exp.size() && i < rcv.size(); i++)
            chk(rq, int'(rcv[i]), int'(exp[i]));
    endtask

    initial begin
        int s0, b0, st0;
        cyc_n(4);
        rst = 0;
        cyc_n(1);
        // reset state: R11 layout, R10 status
        chk("R11 reset fifo_stat", int'(fifo_stat), 32'h0100_0100);
        chk("R10 reset status", int'(xfer_status), 0);
        chk("R10 reset irq", int'(irq_done), 0);
        chk("R1 reset busy/req", int'({xfer_busy, bit_req}), 0);

        // R1 zero length refused
        go(0, 0, 1, 0, 10'h52);
        chk("R1 zero len busy", int'(xfer_busy), 0);
        cyc_n(20);
        chk("R1 zero len no START", start_cnt, 0);
        chk("R1 zero len irq", int'(irq_done), 0);

        // R2/R3 7-bit write, stop
        push_tx(8'hA5); push_tx(8'h3C); push_tx(8'hF0);
        rcv.delete();
        go(3, 0, 1, 0, 10'h52);
        chk("R1 busy after run", int'(xfer_busy), 1);
        wait_idle();
        chk_rcv("R2 R3 write bytes", '{8'hA4, 8'hA5, 8'h3C, 8'hF0});
        chk("R10 write status", int'(xfer_status), 1);
        chk("R10 irq set", int'(irq_done), 1);
        chk("R5 stop issued", stop_cnt, 1);
        chk("R12 busy through stop", int'(busy_at_stop), 1);
        chk("R11 tx drained empty", int'(fifo_stat[8]), 1);
        @(negedge clk); irq_clr = 1; @(negedge clk); irq_clr = 0;
        chk("R10 irq cleared", int'(irq_done), 0);

        // R4 read, no stop
        rd_bytes = '{8'h81, 8'h7E, 8'h5A}; rd_idx = 0; mack.delete(); rcv.delete();
        go(3, 1, 0, 0, 10'h52);
        wait_idle();
        chk("R5 no stop", stop_cnt, 1);
        chk("R10 read status", int'(xfer_status), 1);
        chk("R11 rx level 3", int'(fifo_stat[22:16]), 3);
        chk("R4 ack count", mack.size(), 3);
        if (mack.size() == 3) begin
            chk("R4 ack byte0", mack[0], 0);
            chk("R4 ack byte1", mack[1], 0);
            chk("R4 nack last", mack[2], 1);
        end
        pop_chk("R4 rx byte0", 8'h81); pop_chk("R4 rx byte1", 8'h7E); pop_chk("R4 rx byte2", 8'h5A);

        // R2 10-bit write following held bus: repeated START
        s0 = start_cnt;
        push_tx(8'h11); rcv.delete();
        go(1, 0, 1, 1, 10'h2B7);
        wait_idle();
        chk("R5 repeated start", start_cnt - s0, 1);
        chk_rcv("R2 ten-bit write", '{8'hF4, 8'hB7, 8'h11});
        chk("R5 stop after ten-bit", stop_cnt, 2);

        // R2 10-bit read
        s0 = start_cnt; rd_bytes = '{8'hC3, 8'h96}; rd_idx = 0; rcv.delete();
        go(2, 1, 1, 1, 10'h2B7);
        wait_idle();
        chk("R2 ten-bit read starts", start_cnt - s0, 2);
        chk_rcv("R2 ten-bit read header", '{8'hF4, 8'hB7, 8'hF5});
        pop_chk("R4 ten-bit rx0", 8'hC3); pop_chk("R4 ten-bit rx1", 8'h96);

        // R6 no device
        present = 0; st0 = stop_cnt;
        go(1, 0, 1, 0, 10'h33);
        wait_idle();
        chk("R6 nodev status", int'(xfer_status), 8);
        chk("R6 nodev stop", stop_cnt - st0, 1);
        present = 1;

        // R6 data nack on second data byte
        push_tx(8'h01); push_tx(8'h02); nack_at = 2; rcv.delete(); st0 = stop_cnt;
        go(3, 0, 1, 0, 10'h52);
        wait_idle();
        chk("R6 noack status", int'(xfer_status), 4);
        chk("R6 noack stop", stop_cnt - st0, 1);
        chk("R6 tx empty after nack", int'(fifo_stat[8]), 1);
        nack_at = -1;

        // R7 arbitration lost on first address bit
        arb_at = bits_seen + 1; st0 = stop_cnt;
        go(1, 1, 1, 0, 10'h52);
        wait_idle();
        chk("R7 abort status", int'(xfer_status), 2);
        chk("R7 no stop", stop_cnt - st0, 0);
        arb_at = -1;

        // R9 write stall on empty TX
        b0 = bits_seen;
        go(2, 0, 1, 0, 10'h52);
        cyc_n(100);
        chk("R9 stalled busy", int'(xfer_busy), 1);
        chk("R9 stalled bit count", bits_seen - b0, 9);
        push_tx(8'h5E); push_tx(8'hE5);
        wait_idle();
        chk("R9 write resumes", int'(xfer_status), 1);

        // R9 read stall on full RX
        rd_bytes.delete();
        for (int i = 0; i < DEPTH + 2; i++) rd_bytes.push_back(8'(i * 17 + 3));
        rd_idx = 0;
        go(DEPTH + 2, 1, 1, 0, 10'h52);
        for (int i = 0; i < 5000 && !fifo_stat[23]; i++) @(negedge clk);
        cyc_n(40);
        b0 = bits_seen;
        cyc_n(60);
        chk("R9 rx full stall", bits_seen - b0, 0);
        chk("R11 rx full level", int'(fifo_stat[22:16]), DEPTH);
        for (int i = 0; i < DEPTH + 2; i++) begin
            for (int k = 0; k < 5000 && fifo_stat[24]; k++) @(negedge clk);
            pop_chk("R9 rx data after stall", 8'(i * 17 + 3));
        end
        wait_idle();
        chk("R9 read resumes", int'(xfer_status), 1);

        // R8 timeout enabled
        to_en = 1; to_limit = 20; st0 = stop_cnt;
        @(negedge clk);
        scl_held_low = 1;
        go(1, 1, 1, 0, 10'h52);
        cyc_n(40);
        scl_held_low = 0;
        wait_idle();
        chk("R8 timeout status", int'(xfer_status), 16);
        chk("R8 timeout no stop", stop_cnt - st0, 0);

        // R8 timeout disabled
        to_en = 0; rd_bytes = '{8'h6D}; rd_idx = 0;
        @(negedge clk);
        scl_held_low = 1;
        go(1, 1, 1, 0, 10'h52);
        cyc_n(60);
        chk("R8 disabled still busy", int'(xfer_busy), 1);
        scl_held_low = 0;
        wait_idle();
        chk("R8 disabled success", int'(xfer_status), 1);
        pop_chk("R8 disabled rx", 8'h6D);

        // R11 push on full / pop on empty
        for (int i = 0; i < DEPTH + 1; i++) push_tx(8'(8'h40 + i));
        chk("R11 tx level full", int'(fifo_stat[6:0]), DEPTH);
        chk("R11 tx full flag", int'(fifo_stat[7]), 1);
        @(negedge clk); rx_pop = 1; @(negedge clk); rx_pop = 0;
        chk("R11 pop empty", int'(fifo_stat[22:16]), 0);
        rcv.delete();
        go(DEPTH, 0, 1, 0, 10'h52);
        wait_idle();
        chk("R11 drain status", int'(xfer_status), 1);
        chk("R11 extra push dropped", rcv.size(), DEPTH + 1);
        if (rcv.size() == DEPTH + 1)
            chk("R11 last kept byte", int'(rcv[DEPTH]), 8'h40 + DEPTH - 1);

        summary();
    end
endmodule